// File: doc/BRIEF.md
# Dropped-Packet Cast-Class Counters

This block counts packets thrown away by an upstream random-early-discard stage. Each discard is reported with a one-cycle strobe. The strobe carries the ingress port, the parse mode, the destination MAC address and the destination IP address. For IPv6, only the top byte of the destination address is supplied, on bits [31:24]. The block sorts each discard into four independent classes: link-layer multicast, link-layer broadcast, network-layer multicast and network-layer broadcast. It keeps one saturating counter per class per port.

Software or a statistics collector reads a single counter through a small registered read port. A control input chooses whether that read also zeroes the counter. The number of ports, the width of the port number and the counter width are all parameters. A port number at or above the configured port count is treated as invalid.

Top module: `drop_cast_counters`

## Requirements
- R1: A discard whose destination MAC is all ones (48 bits) is counted as link-layer broadcast. It is not counted as link-layer multicast.
- R2: A discard whose MAC first byte, `dst_mac[47:40]`, has its least significant bit set (`dst_mac[40]`=1) and that is not a broadcast is counted as link-layer multicast. A MAC with `dst_mac[40]`=0 is in neither link-layer class.
- R3: For IPv4 (`is_ipv6`=0), the packet is network-layer multicast when `dst_ip[31:28]` equals 0xE. It is network-layer broadcast when `dst_ip[31:24]` equals 0xFF.
- R4: For IPv6 (`is_ipv6`=1), the packet is network-layer multicast when `dst_ip[31:24]` equals 0xFF. An IPv6 packet is never counted as network-layer broadcast.
- R5: Parse mode is encoded as 0 = none, 1 = skip-to-L2, 2 = skip-to-IP, 3 = reserved. Link-layer counters advance only in mode 1.
- R6: Network-layer counters advance in two cases: in mode 1 when `is_ip`=1, or in mode 2 whatever the value of `is_ip`. Modes 0 and 3 count nothing.
- R7: A read is requested with `rd_en`. One clock later, `rd_vld`=1 and `rd_data` holds the counter selected by `rd_port` and `rd_sel`, as it was before that edge. The `rd_sel` encoding is 0 = L2 multicast, 1 = L2 broadcast, 2 = L3 multicast, 3 = L3 broadcast.
- R8: A read with `clr_on_rd`=1 returns the current value and sets that counter to 0. A read with `clr_on_rd`=0 leaves the counter unchanged.
- R9: Counters are `CNT_W` bits wide (default 32). A counter at its maximum value stays there on further events.
- R10: A discard and a clearing read that reach the same counter in the same cycle leave that counter at 1. The read returns the value before the edge.
- R11: A discard with a port number at or above `NUM_PORTS` changes no counter. A read of such a port returns 0 and clears nothing.
- R12: After reset every counter reads 0 and `rd_vld` is 0.
- R13: With `drop_vld`=0, no counter changes, whatever values the classification inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drop_vld | input | 1 | One-cycle discard strobe |
| drop_port | input | PORT_IN_W | Port of the discarded packet |
| parse_mode | input | 2 | Parse mode of the discarded packet |
| is_ip | input | 1 | Packet was recognised as IP |
| is_ipv6 | input | 1 | 1 = IPv6, 0 = IPv4 |
| dst_mac | input | 48 | Destination MAC, first transmitted byte in [47:40] |
| dst_ip | input | 32 | IPv4 destination, or IPv6 top byte in [31:24] |
| rd_en | input | 1 | Read request |
| rd_port | input | PORT_IN_W | Port to read |
| rd_sel | input | 2 | Class to read |
| clr_on_rd | input | 1 | Zero the counter as it is read |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | CNT_W | Read counter value |

## Verification
A discard presented before a rising edge is reflected in the counter at that same edge. A read presented before edge k returns its data after edge k, so `rd_vld` and `rd_data` are due exactly one cycle after the request. The bench drives every stimulus at a falling edge, removes it at the next falling edge, and samples the read result there, half a cycle after the edge that produced it. Counter contents are always observed through the read port after the discard strobe has been withdrawn. A check on a same-cycle discard and clear therefore sees both the returned old value and the settled new one.

// File: rtl/drop_cast_pkg.sv
package drop_cast_pkg;

    typedef enum logic [1:0] {
        PM_NONE    = 2'd0,
        PM_SKIP_L2 = 2'd1,
        PM_SKIP_IP = 2'd2,
        PM_RSVD    = 2'd3
    } parse_mode_e;

    localparam int NUM_CLASSES = 4;
    localparam int CLS_L2_MC   = 0;
    localparam int CLS_L2_BC   = 1;
    localparam int CLS_L3_MC   = 2;
    localparam int CLS_L3_BC   = 3;

    typedef logic [NUM_CLASSES-1:0] cls_vec_t;

endpackage

// File: rtl/drop_cast_classify.sv
module drop_cast_classify
    import drop_cast_pkg::*;
(
    input  logic [1:0]  parse_mode,
    input  logic        is_ip,
    input  logic        is_ipv6,
    input  logic [47:0] dst_mac,
    input  logic [31:0] dst_ip,
    output cls_vec_t    hit
);

    logic l2_bc, l2_mc, l3_mc, l3_bc;
    logic l2_en, l3_en;

    always_comb begin
        // link-layer: broadcast wins over the group bit
        l2_bc = &dst_mac;
        l2_mc = dst_mac[40] && !l2_bc;

        // network-layer classes depend on address family
        if (is_ipv6) begin
            l3_mc = (dst_ip[31:24] == 8'hFF);
            l3_bc = 1'b0;
        end else begin
            l3_mc = (dst_ip[31:28] == 4'hE);
            l3_bc = (dst_ip[31:24] == 8'hFF);
        end

        l2_en = (parse_mode == PM_SKIP_L2);
        l3_en = ((parse_mode == PM_SKIP_L2) && is_ip) || (parse_mode == PM_SKIP_IP);

        hit            = '0;
        hit[CLS_L2_MC] = l2_en && l2_mc;
        hit[CLS_L2_BC] = l2_en && l2_bc;
        hit[CLS_L3_MC] = l3_en && l3_mc;
        hit[CLS_L3_BC] = l3_en && l3_bc;
    end

endmodule

// File: rtl/drop_sat_counter.sv
module drop_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = inc ? CNT_ONE : '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> (cnt_q == CNT_ONE));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    assert_monotone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> (cnt_q >= $past(cnt_q)));

    assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt_q));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (cnt_q == '0));

endmodule

// File: rtl/drop_cast_counters.sv
module drop_cast_counters
    import drop_cast_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_IN_W = 4,
    parameter int CNT_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 drop_vld,
    input  logic [PORT_IN_W-1:0] drop_port,
    input  logic [1:0]           parse_mode,
    input  logic                 is_ip,
    input  logic                 is_ipv6,
    input  logic [47:0]          dst_mac,
    input  logic [31:0]          dst_ip,
    input  logic                 rd_en,
    input  logic [PORT_IN_W-1:0] rd_port,
    input  logic [1:0]           rd_sel,
    input  logic                 clr_on_rd,
    output logic                 rd_vld,
    output logic [CNT_W-1:0]     rd_data
);

    localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    typedef struct packed {
        logic             vld;
        logic [CNT_W-1:0] data;
    } rd_state_t;

    cls_vec_t         cls_hit;
    logic             drop_in_range;
    logic             rd_in_range;
    logic [PIDX_W-1:0] rd_idx;
    logic [CNT_W-1:0] cnt_arr [NUM_PORTS][NUM_CLASSES];
    rd_state_t        rd_d, rd_q;

    drop_cast_classify u_classify (
        .parse_mode (parse_mode),
        .is_ip      (is_ip),
        .is_ipv6    (is_ipv6),
        .dst_mac    (dst_mac),
        .dst_ip     (dst_ip),
        .hit        (cls_hit)
    );

    assign drop_in_range = (int'(drop_port) < NUM_PORTS);
    assign rd_in_range   = (int'(rd_port) < NUM_PORTS);
    assign rd_idx        = rd_port[PIDX_W-1:0];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic port_drop, port_read;
        assign port_drop = drop_vld && drop_in_range && (int'(drop_port) == p);
        assign port_read = rd_en && clr_on_rd && rd_in_range && (int'(rd_port) == p);

        for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
            logic cls_inc, cls_clr;
            assign cls_inc = port_drop && cls_hit[c];
            assign cls_clr = port_read && (int'(rd_sel) == c);

            drop_sat_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (cls_inc),
                .clr   (cls_clr),
                .cnt_q (cnt_arr[p][c])
            );
        end
    end

    always_comb begin
        rd_d      = rd_q;
        rd_d.vld  = rd_en;
        if (rd_en) begin
            rd_d.data = rd_in_range ? cnt_arr[rd_idx][rd_sel] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_vld  = rd_q.vld;
    assign rd_data = rd_q.data;

    assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_vld);

    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_vld);

    assert_oob_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_in_range) |=> (rd_data == '0));

endmodule

// File: tb/drop_cast_counters_tb.sv
module drop_cast_counters_tb_top;

    localparam int NP   = 4;
    localparam int PW   = 4;
    localparam int CW   = 8;
    localparam int CMAX = 255;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          drop_vld = 1'b0;
    logic [PW-1:0] drop_port = '0;
    logic [1:0]    parse_mode = '0;
    logic          is_ip = 1'b0;
    logic          is_ipv6 = 1'b0;
    logic [47:0]   dst_mac = '0;
    logic [31:0]   dst_ip = '0;
    logic          rd_en = 1'b0;
    logic [PW-1:0] rd_port = '0;
    logic [1:0]    rd_sel = '0;
    logic          clr_on_rd = 1'b0;
    logic          rd_vld;
    logic [CW-1:0] rd_data;

    int total = 0;
    int bad   = 0;
    int expc [NP][4];
    bit finished = 0;

    always #5 clk = ~clk;

    drop_cast_counters #(.NUM_PORTS(NP), .PORT_IN_W(PW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .drop_vld(drop_vld), .drop_port(drop_port),
        .parse_mode(parse_mode), .is_ip(is_ip), .is_ipv6(is_ipv6),
        .dst_mac(dst_mac), .dst_ip(dst_ip), .rd_en(rd_en), .rd_port(rd_port),
        .rd_sel(rd_sel), .clr_on_rd(clr_on_rd), .rd_vld(rd_vld), .rd_data(rd_data)
    );

    task automatic chk(string req, int act, int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // model of the requirements: R1..R6, R9, R11
    task automatic model_drop(int port, int mode, bit ip, bit v6, logic [47:0] mac, logic [31:0] dip);
        bit l2bc, l2mc, l3mc, l3bc, l2en, l3en;
        if (port >= NP) return;
        l2bc = (mac == 48'hFFFF_FFFF_FFFF);
        l2mc = mac[40] && !l2bc;
        l3mc = v6 ? (dip[31:24] == 8'hFF) : (dip[31:28] == 4'hE);
        l3bc = v6 ? 1'b0 : (dip[31:24] == 8'hFF);
        l2en = (mode == 1);
        l3en = (mode == 1 && ip) || (mode == 2);
        if (l2en && l2mc && expc[port][0] < CMAX) expc[port][0]++;
        if (l2en && l2bc && expc[port][1] < CMAX) expc[port][1]++;
        if (l3en && l3mc && expc[port][2] < CMAX) expc[port][2]++;
        if (l3en && l3bc && expc[port][3] < CMAX) expc[port][3]++;
    endtask

    task automatic drop(int port, int mode, bit ip, bit v6, logic [47:0] mac, logic [31:0] dip);
        @(negedge clk);
        drop_vld = 1'b1; drop_port = PW'(port); parse_mode = 2'(mode);
        is_ip = ip; is_ipv6 = v6; dst_mac = mac; dst_ip = dip;
        @(negedge clk);
        drop_vld = 1'b0;
        model_drop(port, mode, ip, v6, mac, dip);
    endtask

    task automatic rd(int port, int sel, bit clr, output int val, output bit vld);
        @(negedge clk);
        rd_en = 1'b1; rd_port = PW'(port); rd_sel = 2'(sel); clr_on_rd = clr;
        @(negedge clk);
        rd_en = 1'b0; clr_on_rd = 1'b0;
        val = int'(rd_data);
        vld = rd_vld;
    endtask

    task automatic check_all(string req);
        int v; bit vl;
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 4; c++) begin
                rd(p, c, 1'b0, v, vl);
                chk(req, v, expc[p][c]);
            end
        end
    endtask

    task automatic t_reset();
        chk("R12 rd_vld after reset", int'(rd_vld), 0);
        check_all("R12 reset counters");
    endtask

    task automatic t_read_valid();
        int v; bit vl;
        rd(0, 0, 1'b0, v, vl);
        chk("R7 rd_vld one cycle after request", int'(vl), 1);
        @(negedge clk);
        chk("R7 rd_vld drops without request", int'(rd_vld), 0);
    endtask

    task automatic t_l2();
        drop(0, 1, 0, 0, 48'hFFFF_FFFF_FFFF, 32'h0);   // R1 broadcast
        drop(0, 1, 0, 0, 48'h0100_5E00_0001, 32'h0);   // R2 multicast
        drop(1, 1, 0, 0, 48'hFFFF_FFFF_FFFE, 32'h0);   // R2 group bit set, not all ones
        drop(1, 1, 0, 0, 48'h0200_0000_0001, 32'h0);   // R2 unicast: nothing
        check_all("R1 R2 link-layer classes");
    endtask

    task automatic t_l3_v4();
        drop(2, 1, 1, 0, 48'h0, 32'hE000_0001);   // R3 multicast
        drop(2, 1, 1, 0, 48'h0, 32'hEFFF_FFFF);   // R3 multicast
        drop(2, 2, 0, 0, 48'h0, 32'hFF00_0000);   // R3 broadcast via skip-to-IP
        drop(2, 1, 1, 0, 48'h0, 32'h0A00_0001);   // R3 unicast
        drop(2, 1, 0, 0, 48'h0, 32'hE000_0001);   // R6 not IP in skip-to-L2
        check_all("R3 R6 IPv4 classes");
    endtask

    task automatic t_l3_v6();
        drop(3, 1, 1, 1, 48'h0, 32'hFF02_0000);   // R4 multicast, never bcast
        drop(3, 2, 0, 1, 48'h0, 32'hFE80_0000);   // R4 unicast
        check_all("R4 IPv6 classes");
    endtask

    task automatic t_modes();
        drop(1, 2, 1, 0, 48'hFFFF_FFFF_FFFF, 32'hFFFF_FFFF);  // R5 no L2 in skip-to-IP
        drop(1, 0, 1, 0, 48'hFFFF_FFFF_FFFF, 32'hFFFF_FFFF);  // R6 none
        drop(1, 3, 1, 0, 48'hFFFF_FFFF_FFFF, 32'hFFFF_FFFF);  // R6 reserved
        check_all("R5 R6 parse modes");
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        drop_port = 0; parse_mode = 2'd1; is_ip = 1; is_ipv6 = 0;
        dst_mac = 48'hFFFF_FFFF_FFFF; dst_ip = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check_all("R13 no strobe no count");
    endtask

    task automatic t_oob();
        int v; bit vl;
        drop(9, 1, 1, 0, 48'hFFFF_FFFF_FFFF, 32'hFF00_0000);
        drop(4, 1, 1, 0, 48'h0100_0000_0000, 32'hE000_0000);
        check_all("R11 out-of-range drop ignored");
        rd(9, 1, 1'b1, v, vl);
        chk("R11 out-of-range read returns zero", v, 0);
        check_all("R11 out-of-range read clears nothing");
    endtask

    task automatic t_clear();
        int v; bit vl;
        rd(2, 2, 1'b1, v, vl);
        chk("R8 clearing read returns value", v, expc[2][2]);
        expc[2][2] = 0;
        rd(2, 2, 1'b0, v, vl);
        chk("R8 counter zero after clear", v, 0);
        rd(0, 1, 1'b0, v, vl);
        chk("R8 plain read returns value", v, expc[0][1]);
        rd(0, 1, 1'b0, v, vl);
        chk("R8 plain read keeps value", v, expc[0][1]);
    endtask

    task automatic t_same_cycle();
        int v;
        drop(0, 1, 0, 0, 48'hFFFF_FFFF_FFFF, 32'h0);
        @(negedge clk);
        drop_vld = 1'b1; drop_port = 0; parse_mode = 2'd1; is_ip = 0; is_ipv6 = 0;
        dst_mac = 48'hFFFF_FFFF_FFFF; dst_ip = 32'h0;
        rd_en = 1'b1; rd_port = 0; rd_sel = 2'd1; clr_on_rd = 1'b1;
        @(negedge clk);
        drop_vld = 1'b0; rd_en = 1'b0; clr_on_rd = 1'b0;
        v = int'(rd_data);
        chk("R10 read returns pre-edge value", v, expc[0][1]);
        expc[0][1] = 1;
        check_all("R10 counter ends at one");
    endtask

    task automatic t_saturate();
        int v; bit vl;
        for (int i = 0; i < CMAX + 5; i++) drop(3, 2, 0, 0, 48'h0, 32'hFF00_0000);
        rd(3, 3, 1'b0, v, vl);
        chk("R9 counter saturates", v, CMAX);
        drop(3, 2, 0, 0, 48'h0, 32'hFF00_0000);
        rd(3, 3, 1'b1, v, vl);
        chk("R9 holds at max", v, CMAX);
        expc[3][3] = 0;
        check_all("R9 R8 after saturation clear");
    endtask

    initial begin
        for (int p = 0; p < NP; p++) for (int c = 0; c < 4; c++) expc[p][c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_valid();
        t_l2();
        t_l3_v4();
        t_l3_v6();
        t_modes();
        t_no_strobe();
        t_oob();
        t_clear();
        t_same_cycle();
        t_saturate();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule